// File: doc/BRIEF.md
# DMA Page Register Bank

This block holds the page bytes that a four-channel DMA controller places above its 16-bit current address to reach a full physical address. Each channel owns one low page byte and one high page byte. The two kinds sit in separate banks, and each bank has its own byte-wide port window. A 3-bit port offset selects the channel through a fixed, sparse decode. Four of the eight offsets belong to no channel: a write to one of them is dropped and a read from one returns zero.

The transfer engine presents a channel number and that channel's current address. The block returns the physical address: seven high-page bits, then eight low-page bits, then the 16 address bits. The high bank can be switched off with an enable input. While it is off, its window decodes nothing, and the high field of every formed address is zero. Writes take effect at the next rising clock edge. Reads and address formation are combinational.

Top module: `dma_page_bank`

## Requirements
- R1: After reset every low and every high page byte reads 0 at every offset.
- R2: Port offsets decode to channels as follows: offset 7 is channel 0, offset 3 is channel 1, offset 1 is channel 2 and offset 2 is channel 3. A write at a mapped offset stores the byte for that channel, and a read at the same offset returns it.
- R3: Offsets 0, 4, 5 and 6 are unmapped. A write at one of them changes no stored byte, and a read at one of them returns 0.
- R4: The low and high banks are independent: a write to one bank leaves every byte of the other bank unchanged.
- R5: `xl_phys` is {high page bits [6:0], low page byte, `xl_addr`} of the channel on `xl_chan`. Bit 7 of the high page byte never reaches `xl_phys`.
- R6: While `hi_en` is 0, high-bank writes are dropped and high-bank reads return 0. A byte stored earlier reads back again once `hi_en` returns to 1.
- R7: While `hi_en` is 0, `xl_phys[30:24]` is 0.
- R8: A write is not visible before the rising edge that captures it. It is visible on the read port straight after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hi_en | input | 1 | Enables the high page bank |
| lo_wr_en | input | 1 | Low bank write strobe |
| lo_wr_off | input | 3 | Low bank write offset |
| lo_wr_data | input | 8 | Low bank write byte |
| lo_rd_off | input | 3 | Low bank read offset |
| lo_rd_data | output | 8 | Low bank read byte |
| hi_wr_en | input | 1 | High bank write strobe |
| hi_wr_off | input | 3 | High bank write offset |
| hi_wr_data | input | 8 | High bank write byte |
| hi_rd_off | input | 3 | High bank read offset |
| hi_rd_data | output | 8 | High bank read byte |
| xl_chan | input | 2 | Channel whose address is formed |
| xl_addr | input | 16 | That channel's current address |
| xl_phys | output | 31 | Formed physical address |

## Verification
A write is due one rising edge after its strobe is driven. Read data and `xl_phys` follow their select inputs within the same cycle. The bench therefore drives inputs on falling edges and reads results a short delay after each change. For R8 it samples once before the capturing edge and once after it, expecting the old byte and then the new one. Checks on dropped writes (R3, R6) read back through the normal read ports after the edge that would have captured the write.

// File: rtl/dma_page_bank.sv
module dma_page_bank #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  parameter int HI_USE = 7
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          hi_en,
  input  logic                          lo_wr_en,
  input  logic [2:0]                    lo_wr_off,
  input  logic [PAGE_W-1:0]             lo_wr_data,
  input  logic [2:0]                    lo_rd_off,
  output logic [PAGE_W-1:0]             lo_rd_data,
  input  logic                          hi_wr_en,
  input  logic [2:0]                    hi_wr_off,
  input  logic [PAGE_W-1:0]             hi_wr_data,
  input  logic [2:0]                    hi_rd_off,
  output logic [PAGE_W-1:0]             hi_rd_data,
  input  logic [1:0]                    xl_chan,
  input  logic [ADDR_W-1:0]             xl_addr,
  output logic [HI_USE+PAGE_W+ADDR_W-1:0] xl_phys
);
  localparam int NCH = 4;

  // returns {hit, channel}
  function automatic logic [2:0] decode(input logic [2:0] off);
    case (off)
      3'd7:    decode = {1'b1, 2'd0};
      3'd3:    decode = {1'b1, 2'd1};
      3'd1:    decode = {1'b1, 2'd2};
      3'd2:    decode = {1'b1, 2'd3};
      default: decode = 3'b000;
    endcase
  endfunction

  logic [NCH-1:0][PAGE_W-1:0] lo_q, hi_q;
  logic [2:0] lo_w, hi_w, lo_r, hi_r;

  assign lo_w = decode(lo_wr_off);
  assign hi_w = decode(hi_wr_off);
  assign lo_r = decode(lo_rd_off);
  assign hi_r = decode(hi_rd_off);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[c] <= '0;
        hi_q[c] <= '0;
      end else begin
        if (lo_wr_en && lo_w[2] && lo_w[1:0] == c[1:0])
          lo_q[c] <= lo_wr_data;
        if (hi_en && hi_wr_en && hi_w[2] && hi_w[1:0] == c[1:0])
          hi_q[c] <= hi_wr_data;
      end
    end
  end

  assign lo_rd_data = lo_r[2] ? lo_q[lo_r[1:0]] : '0;
  assign hi_rd_data = (hi_en && hi_r[2]) ? hi_q[hi_r[1:0]] : '0;

  logic [HI_USE-1:0] hi_fld;
  assign hi_fld  = hi_en ? hi_q[xl_chan][HI_USE-1:0] : '0;
  assign xl_phys = {hi_fld, lo_q[xl_chan], xl_addr};
endmodule

// File: rtl/dma_page_bank_chk.sv
module dma_page_bank_chk #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  parameter int HI_USE = 7
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            hi_en,
  input logic                            lo_wr_en,
  input logic [2:0]                      lo_wr_off,
  input logic [PAGE_W-1:0]               lo_wr_data,
  input logic [2:0]                      lo_rd_off,
  input logic [PAGE_W-1:0]               lo_rd_data,
  input logic                            hi_wr_en,
  input logic [2:0]                      hi_rd_off,
  input logic [PAGE_W-1:0]               hi_rd_data,
  input logic [1:0]                      xl_chan,
  input logic [ADDR_W-1:0]               xl_addr,
  input logic [HI_USE+PAGE_W+ADDR_W-1:0] xl_phys,
  input logic [3:0][PAGE_W-1:0]          lo_q,
  input logic [3:0][PAGE_W-1:0]          hi_q
);
  localparam int PHYS_W = HI_USE + PAGE_W + ADDR_W;

  function automatic logic unmapped(input logic [2:0] off);
    unmapped = (off == 3'd0) || (off == 3'd4) || (off == 3'd5) || (off == 3'd6);
  endfunction

  function automatic logic [1:0] chan_of(input logic [2:0] off);
    case (off)
      3'd7:    chan_of = 2'd0;
      3'd3:    chan_of = 2'd1;
      3'd1:    chan_of = 2'd2;
      default: chan_of = 2'd3;
    endcase
  endfunction

  // R3
  unmapped_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped(lo_rd_off) |-> lo_rd_data == '0);

  // R3
  unmapped_wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_wr_en && unmapped(lo_wr_off)) |=> $stable(lo_q));

  // R2
  lo_wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_wr_en && !unmapped(lo_wr_off)) |=>
      lo_q[chan_of($past(lo_wr_off))] == $past(lo_wr_data));

  // R4
  lo_wr_spares_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_wr_en && !hi_wr_en) |=> $stable(hi_q));

  // R6
  hi_off_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_en |-> hi_rd_data == '0);

  // R6
  hi_off_wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_en |=> $stable(hi_q));

  // R5
  phys_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xl_phys[ADDR_W-1:0] == xl_addr && xl_phys[ADDR_W +: PAGE_W] == lo_q[xl_chan]);

  // R7
  hi_field_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_en |-> xl_phys[PHYS_W-1 -: HI_USE] == '0);
endmodule

bind dma_page_bank dma_page_bank_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .HI_USE(HI_USE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hi_en(hi_en),
  .lo_wr_en(lo_wr_en), .lo_wr_off(lo_wr_off), .lo_wr_data(lo_wr_data),
  .lo_rd_off(lo_rd_off), .lo_rd_data(lo_rd_data),
  .hi_wr_en(hi_wr_en), .hi_rd_off(hi_rd_off), .hi_rd_data(hi_rd_data),
  .xl_chan(xl_chan), .xl_addr(xl_addr), .xl_phys(xl_phys),
  .lo_q(lo_q), .hi_q(hi_q)
);

// File: tb/dma_page_bank_bench.sv
`timescale 1ns/1ps
module dma_page_bank_bench;
  logic clk = 1'b0, rst_n = 1'b0, hi_en = 1'b1;
  logic lo_wr_en = 1'b0, hi_wr_en = 1'b0;
  logic [2:0] lo_wr_off = '0, lo_rd_off = '0, hi_wr_off = '0, hi_rd_off = '0;
  logic [7:0] lo_wr_data = '0, hi_wr_data = '0, lo_rd_data, hi_rd_data;
  logic [1:0] xl_chan = '0;
  logic [15:0] xl_addr = '0;
  logic [30:0] xl_phys;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dma_page_bank u_dma_page_bank (
    .clk(clk), .rst_n(rst_n), .hi_en(hi_en),
    .lo_wr_en(lo_wr_en), .lo_wr_off(lo_wr_off), .lo_wr_data(lo_wr_data),
    .lo_rd_off(lo_rd_off), .lo_rd_data(lo_rd_data),
    .hi_wr_en(hi_wr_en), .hi_wr_off(hi_wr_off), .hi_wr_data(hi_wr_data),
    .hi_rd_off(hi_rd_off), .hi_rd_data(hi_rd_data),
    .xl_chan(xl_chan), .xl_addr(xl_addr), .xl_phys(xl_phys)
  );

  // {wr_bank, wr_off, wr_data, rd_bank, rd_off, expected}; bank 1 = high
  localparam logic [23:0] VEC [12] = '{
    {1'b0, 3'd7, 8'hAA, 1'b0, 3'd7, 8'hAA},  // R2 ch0
    {1'b0, 3'd3, 8'h11, 1'b0, 3'd3, 8'h11},  // R2 ch1
    {1'b0, 3'd1, 8'h22, 1'b0, 3'd1, 8'h22},  // R2 ch2
    {1'b0, 3'd2, 8'h33, 1'b0, 3'd2, 8'h33},  // R2 ch3
    {1'b0, 3'd0, 8'h55, 1'b0, 3'd7, 8'hAA},  // R3 dropped write
    {1'b0, 3'd4, 8'h66, 1'b0, 3'd4, 8'h00},  // R3 unmapped read
    {1'b0, 3'd5, 8'h67, 1'b0, 3'd3, 8'h11},  // R3
    {1'b0, 3'd6, 8'h68, 1'b0, 3'd6, 8'h00},  // R3
    {1'b1, 3'd7, 8'hF1, 1'b1, 3'd7, 8'hF1},  // R4 high ch0
    {1'b1, 3'd7, 8'hF1, 1'b0, 3'd7, 8'hAA},  // R4 low untouched
    {1'b1, 3'd3, 8'h82, 1'b1, 3'd3, 8'h82},  // R4 high ch1
    {1'b0, 3'd1, 8'h5A, 1'b1, 3'd1, 8'h00}   // R4 high ch2 untouched
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(bit bank, logic [2:0] off, logic [7:0] d);
    @(negedge clk);
    if (bank) begin hi_wr_en = 1; hi_wr_off = off; hi_wr_data = d; end
    else      begin lo_wr_en = 1; lo_wr_off = off; lo_wr_data = d; end
    @(negedge clk);
    lo_wr_en = 0; hi_wr_en = 0;
  endtask

  task automatic rd(bit bank, logic [2:0] off, output logic [7:0] v);
    if (bank) hi_rd_off = off; else lo_rd_off = off;
    #1;
    v = bank ? hi_rd_data : lo_rd_data;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int o = 0; o < 8; o++) begin
      rd(0, o[2:0], v); chk("R1 low", {24'h0, v}, 32'h0);
      rd(1, o[2:0], v); chk("R1 high", {24'h0, v}, 32'h0);
    end

    for (int i = 0; i < 12; i++) begin
      wr(VEC[i][23], VEC[i][22:20], VEC[i][19:12]);
      rd(VEC[i][11], VEC[i][10:8], v);
      chk($sformatf("R2/R3/R4 vec%0d", i), {24'h0, v}, {24'h0, VEC[i][7:0]});
    end

    // R5 address formation, high bit 7 dropped
    @(negedge clk);
    xl_chan = 2'd0; xl_addr = 16'h1234; #1;
    chk("R5 ch0", {1'b0, xl_phys}, {1'b0, 7'h71, 8'hAA, 16'h1234});
    xl_chan = 2'd1; xl_addr = 16'hFFFF; #1;
    chk("R5 ch1", {1'b0, xl_phys}, {1'b0, 7'h02, 8'h11, 16'hFFFF});
    xl_chan = 2'd2; xl_addr = 16'h0001; #1;
    chk("R5 ch2", {1'b0, xl_phys}, {1'b0, 7'h00, 8'h5A, 16'h0001});

    // R6 / R7 high bank disabled
    @(negedge clk);
    hi_en = 0;
    xl_chan = 2'd0; xl_addr = 16'h1234; #1;
    chk("R7 hi field", {1'b0, xl_phys}, {1'b0, 7'h00, 8'hAA, 16'h1234});
    rd(1, 3'd7, v); chk("R6 read off", {24'h0, v}, 32'h0);
    wr(1, 3'd7, 8'h0C);
    wr(1, 3'd2, 8'h0D);
    @(negedge clk);
    hi_en = 1;
    rd(1, 3'd7, v); chk("R6 write dropped ch0", {24'h0, v}, 32'hF1);
    rd(1, 3'd2, v); chk("R6 write dropped ch3", {24'h0, v}, 32'h00);
    #1;
    chk("R7 restored", {1'b0, xl_phys}, {1'b0, 7'h71, 8'hAA, 16'h1234});

    // R8 write timing
    @(negedge clk);
    lo_rd_off = 3'd2;
    lo_wr_en = 1; lo_wr_off = 3'd2; lo_wr_data = 8'hC3;
    #1;
    chk("R8 before edge", {24'h0, lo_rd_data}, 32'h33);
    @(posedge clk); #1;
    chk("R8 after edge", {24'h0, lo_rd_data}, 32'hC3);
    @(negedge clk);
    lo_wr_en = 0;

    // R1 reset again
    rst_n = 0; #1;
    rd(0, 3'd2, v); chk("R1 low after reset", {24'h0, v}, 32'h0);
    rd(1, 3'd7, v); chk("R1 high after reset", {24'h0, v}, 32'h0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    finish_up();
  end
endmodule